// File: doc/BRIEF.md
# ADC Result Block-Transfer Controller

This controller moves converter results into system memory with no processor involvement. Each time the converter presents a valid 10-bit result while the unit is running, the controller issues one 16-bit word write on a simple memory write port. The result is zero-extended into the word. Successive writes go to successive word addresses. Results are grouped into blocks whose length is set by an 8-bit transfer count. A one-cycle completion pulse marks the end of every block, so software is interrupted once per block rather than once per sample.

Two layouts are supported. In the single-buffer layout one block is filled. In the ping-pong layout a second block follows the first directly in memory, and a status bit tells software which half was filled last, so it can work on the other half. A one-shot run stops after the final block. A continuous run wraps back to the base address and carries on until the continuous bit is cleared or the base address is rewritten. Writing the base address halts the unit and resets its position. A run then starts only when the unit is armed again. A transfer count of zero keeps the unit disabled.

Top module: `adc_xfer_ctrl`

## Requirements
- R1: After reset the unit is idle (`busy`=0, `mem_wr`=0, `blk_done`=0, `last_block`=0) and the base address is 0x0200, so the first write after arming goes to 0x0200.
- R2: While busy, each cycle with `res_valid`=1 (and no `arm` or `base_wr`) produces exactly one write in the next cycle: `mem_wdata` holds the result zero-extended to 16 bits, and `mem_addr` is base + 2*n, where n is the position of the transfer in the current pass.
- R3: A transfer count of 0 disables the unit: `arm` with a count of 0 leaves `busy` at 0, and no write is issued while the count is 0.
- R4: In single-buffer mode (`two_block`=0) with `continuous`=0, the run stops after `xfer_count` writes. `blk_done` pulses for one cycle together with the last write, and `busy` is 0 from that same cycle.
- R5: In ping-pong mode (`two_block`=1), the second block begins at base + 2*`xfer_count`. `blk_done` pulses with the last write of each block, and a one-shot run stops after both blocks.
- R6: With `continuous`=1, after the final block the next write goes back to the base address and the unit stays busy.
- R7: If `continuous` is cleared while a run is active, the unit stops at the end of the final block of the current pass, as a one-shot run would.
- R8: A `base_wr` pulse loads `base_wdata` as the new base address, stops the unit, and resets its block and transfer position. A result offered in that same cycle is not written. After a new `arm`, writing starts at the new base.
- R9: `last_block` holds the index of the block most recently completed (0 = first, 1 = second), is updated only with `blk_done`, and stays 0 in single-buffer mode.
- R10: Results offered while the unit is idle cause no write.
- R11: An `arm` pulse while busy restarts the pass at the base address with block 0, and a result offered in that same cycle is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_count | input | 8 | Transfers per block; 0 disables |
| two_block | input | 1 | 0 = single buffer, 1 = ping-pong pair |
| continuous | input | 1 | 1 = wrap and keep running |
| arm | input | 1 | Pulse: start a pass from the base address |
| base_wr | input | 1 | Pulse: load a new base address and halt |
| base_wdata | input | 16 | New base address |
| res_valid | input | 1 | Converter result strobe |
| res_data | input | 10 | Converter result |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| blk_done | output | 1 | Block-complete interrupt-flag pulse |
| last_block | output | 1 | Block most recently filled |
| busy | output | 1 | Unit running |

## Verification
A write, its address and data, and the matching `blk_done` pulse all appear one clock after the edge that samples `res_valid`. `last_block` changes on that same edge. `busy` changes on the edge that samples `arm`, `base_wr` or the final result of a pass, so it drops in the same cycle as the final write. The bench's behavioural model updates on every rising edge from the inputs the design sees at that edge. All outputs are then compared on the following falling edge, which places each comparison in exactly the cycle in which the result is due.

// File: rtl/adc_xfer_pkg.sv
package adc_xfer_pkg;
  typedef enum logic {BLK_A = 1'b0, BLK_B = 1'b1} blk_sel_e;
endpackage

// File: rtl/adc_xfer_seq.sv
module adc_xfer_seq
  import adc_xfer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] xfer_count,
  input  logic             two_block,
  input  logic             continuous,
  input  logic             arm,
  input  logic             base_wr,
  input  logic             res_valid,
  output logic             busy,
  output logic             take,
  output logic             blk_end,
  output logic [CNT_W-1:0] idx,
  output blk_sel_e         blk
);
  logic final_blk;
  logic run_end;
  logic cnt_zero;

  assign cnt_zero  = (xfer_count == '0);
  assign take      = busy && !cnt_zero && res_valid && !base_wr && !arm;
  assign blk_end   = take && (idx == xfer_count - 1'b1);
  assign final_blk = !two_block || (blk == BLK_B);
  assign run_end   = blk_end && final_blk && !continuous;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      blk  <= BLK_A;
    end else if (base_wr) begin
      busy <= 1'b0;
      idx  <= '0;
      blk  <= BLK_A;
    end else if (arm) begin
      busy <= !cnt_zero;
      idx  <= '0;
      blk  <= BLK_A;
    end else if (take) begin
      if (blk_end) begin
        idx <= '0;
        blk <= final_blk ? BLK_A : BLK_B;
        if (run_end) busy <= 1'b0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  // R2: position never reaches the block length while running
  a_r2_idx_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cnt_zero && $stable(xfer_count)) |-> (idx < xfer_count));
  // R5: second block only exists in ping-pong mode
  a_r5_blk_b_needs_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (take && blk == BLK_B) |-> two_block);
endmodule

// File: rtl/adc_xfer_addr.sv
module adc_xfer_addr
  import adc_xfer_pkg::*;
#(
  parameter int              CNT_W      = 8,
  parameter int              ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 16'h0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic [CNT_W-1:0]  xfer_count,
  input  blk_sel_e          blk,
  input  logic [CNT_W-1:0]  idx,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int OFF_W = CNT_W + 1;

  logic [ADDR_W-1:0] base_q;

  function automatic logic [ADDR_W-1:0] word_addr(
    input logic [ADDR_W-1:0] base,
    input blk_sel_e          b,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  pos
  );
    logic [OFF_W-1:0] words;
    words = {1'b0, pos} + ((b == BLK_B) ? {1'b0, cnt} : '0);
    return base + (ADDR_W'(words) << 1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= RESET_ADDR;
    else if (base_wr) base_q <= base_wdata;
  end

  assign cur_addr = word_addr(base_q, blk, xfer_count, idx);

  // R8: base changes only through the load pulse
  a_r8_base_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(base_wr) |-> $stable(base_q));
endmodule

// File: rtl/adc_xfer_wr.sv
module adc_xfer_wr
  import adc_xfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int RES_W  = 10,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              blk_end,
  input  blk_sel_e          blk,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [RES_W-1:0]  res_data,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              blk_done,
  output logic              last_block
);
  function automatic logic [WORD_W-1:0] widen(input logic [RES_W-1:0] r);
    return WORD_W'(r);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_wr     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      blk_done   <= 1'b0;
      last_block <= 1'b0;
    end else begin
      mem_wr   <= take;
      blk_done <= blk_end;
      if (take) begin
        mem_addr  <= cur_addr;
        mem_wdata <= widen(res_data);
      end
      if (blk_end) last_block <= (blk == BLK_B);
    end
  end

  // R4: completion pulse always accompanies a write
  a_r4_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> mem_wr);
  // R9: status changes only with a completion pulse
  a_r9_last_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_done |-> $stable(last_block));
endmodule

// File: rtl/adc_xfer_ctrl.sv
module adc_xfer_ctrl
  import adc_xfer_pkg::*;
#(
  parameter int                CNT_W      = 8,
  parameter int                ADDR_W     = 16,
  parameter int                RES_W      = 10,
  parameter int                WORD_W     = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 16'h0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  xfer_count,
  input  logic              two_block,
  input  logic              continuous,
  input  logic              arm,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              res_valid,
  input  logic [RES_W-1:0]  res_data,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              blk_done,
  output logic              last_block,
  output logic              busy
);
  logic             take;
  logic             blk_end;
  logic [CNT_W-1:0] idx;
  blk_sel_e         blk;
  logic [ADDR_W-1:0] cur_addr;

  adc_xfer_seq #(.CNT_W(CNT_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .xfer_count(xfer_count), .two_block(two_block),
    .continuous(continuous), .arm(arm), .base_wr(base_wr), .res_valid(res_valid),
    .busy(busy), .take(take), .blk_end(blk_end), .idx(idx), .blk(blk)
  );

  adc_xfer_addr #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) i_addr (
    .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_wdata(base_wdata),
    .xfer_count(xfer_count), .blk(blk), .idx(idx), .cur_addr(cur_addr)
  );

  adc_xfer_wr #(.ADDR_W(ADDR_W), .RES_W(RES_W), .WORD_W(WORD_W)) i_wr (
    .clk(clk), .rst_n(rst_n), .take(take), .blk_end(blk_end), .blk(blk),
    .cur_addr(cur_addr), .res_data(res_data), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .blk_done(blk_done), .last_block(last_block)
  );

  // R3: a zero count blocks writing
  a_r3_zero_count_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(xfer_count) == '0) |-> !mem_wr);
  // R8: a base load suppresses the write of that cycle
  a_r8_no_write_after_base: assert property (@(posedge clk) disable iff (!rst_n)
    $past(base_wr) |-> !mem_wr);
  // R10: no write without a result
  a_r10_write_needs_result: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(res_valid));
  // R4: the unit stops only at a pass end, a base load or an arm
  a_r4_busy_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (blk_done || $past(base_wr) || $past(arm)));
endmodule

// File: tb/test_adc_xfer_ctrl.sv
module test_adc_xfer_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  xfer_count = '0;
  logic        two_block = 1'b0, continuous = 1'b0, arm = 1'b0, base_wr = 1'b0;
  logic [15:0] base_wdata = '0;
  logic        res_valid = 1'b0;
  logic [9:0]  res_data = '0;
  logic        mem_wr, blk_done, last_block, busy;
  logic [15:0] mem_addr, mem_wdata;

  int checks = 0, errors = 0;
  string tag = "R1";
  int seed = 7;

  // reference model state
  int m_active, m_n, m_start, m_last, e_wr, e_done, e_addr, e_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_xfer_ctrl i_adc_xfer_ctrl (
    .clk(clk), .rst_n(rst_n), .xfer_count(xfer_count), .two_block(two_block),
    .continuous(continuous), .arm(arm), .base_wr(base_wr), .base_wdata(base_wdata),
    .res_valid(res_valid), .res_data(res_data), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .blk_done(blk_done), .last_block(last_block), .busy(busy)
  );

  task automatic chk(string t, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
    end
  endtask

  // behavioural reference: index counts transfers within the whole pass
  always @(posedge clk) begin
    e_wr = 0; e_done = 0;
    if (!rst_n) begin
      m_active = 0; m_n = 0; m_start = 'h200; m_last = 0;
    end else if (base_wr) begin
      m_start = int'(base_wdata); m_active = 0; m_n = 0;
    end else if (arm) begin
      m_active = (xfer_count != 0); m_n = 0;
    end else if (m_active != 0 && xfer_count != 0 && res_valid) begin
      e_wr = 1;
      e_addr = (m_start + 2 * m_n) & 'hffff;
      e_data = int'(res_data);
      m_n++;
      if (m_n % int'(xfer_count) == 0) begin
        e_done = 1;
        m_last = m_n / int'(xfer_count) - 1;
      end
      if (m_n == (two_block ? 2 : 1) * int'(xfer_count)) begin
        m_n = 0;
        if (!continuous) m_active = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(tag, "mem_wr", int'(mem_wr), e_wr);
      if (e_wr != 0) begin
        chk(tag, "mem_addr", int'(mem_addr), e_addr);
        chk(tag, "mem_wdata", int'(mem_wdata), e_data);
      end
      chk(tag, "blk_done", int'(blk_done), e_done);
      chk(tag, "busy", int'(busy), m_active);
      chk(tag, "last_block", int'(last_block), m_last);
    end
  end

  task automatic pulse_arm();
    @(negedge clk); arm = 1'b1; @(negedge clk); arm = 1'b0;
  endtask

  task automatic load_base(input logic [15:0] a, input bit with_res);
    @(negedge clk); base_wr = 1'b1; base_wdata = a;
    res_valid = with_res; res_data = 10'h155;
    @(negedge clk); base_wr = 1'b0; res_valid = 1'b0;
  endtask

  task automatic feed(input int n, input int gap);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      seed = (seed * 1103 + 12345) & 'hffff;
      res_valid = 1'b1; res_data = 10'(seed);
      @(negedge clk); res_valid = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "reset busy", int'(busy), 0);
    chk("R1", "reset mem_wr", int'(mem_wr), 0);
    chk("R1", "reset last_block", int'(last_block), 0);
    chk("R1", "reset blk_done", int'(blk_done), 0);

    tag = "R10"; xfer_count = 8'd4;
    feed(3, 1);                          // idle: ignored

    tag = "R3"; xfer_count = 8'd0;
    pulse_arm(); feed(3, 0);             // zero count: stays idle

    tag = "R2"; xfer_count = 8'd4;       // first pass also proves R1 base 0x200
    pulse_arm(); feed(2, 2);
    tag = "R4"; feed(4, 0);              // block ends, extra results ignored

    tag = "R5"; two_block = 1'b1; xfer_count = 8'd3;
    pulse_arm(); feed(5, 1);
    tag = "R9"; feed(3, 0);

    tag = "R6"; continuous = 1'b1; xfer_count = 8'd2;
    pulse_arm(); feed(10, 0);
    tag = "R7"; continuous = 1'b0; feed(6, 0);

    tag = "R8"; continuous = 1'b1;
    pulse_arm(); feed(3, 0);
    load_base(16'h1000, 1'b1);           // result in same cycle discarded
    feed(2, 0);
    pulse_arm(); feed(5, 0);

    tag = "R11"; two_block = 1'b0; xfer_count = 8'd5;
    pulse_arm(); feed(3, 0);
    @(negedge clk); arm = 1'b1; res_valid = 1'b1; res_data = 10'h3ff;
    @(negedge clk); arm = 1'b0; res_valid = 1'b0;
    feed(6, 0);

    tag = "R4"; continuous = 1'b0; xfer_count = 8'd255;
    pulse_arm(); feed(257, 0);           // largest count boundary

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule